// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

This block is the countdown timer of a per-processor interrupt controller. Software loads a start value, picks a power-of-two clock divider and programs a small control entry. The control entry holds an 8-bit vector, a mask bit and a mode bit that selects one-shot or periodic operation. The counter steps down once per divided tick. When a period ends, the block sends a one-cycle request, with the vector beside it, to the priority logic that sits downstream.

Register access is a simple single-cycle port. A write commits on the rising clock edge while `reg_wr` is high. Read data is a combinational function of `reg_addr`. The register selected by `reg_addr` is: 0 start value, 1 live count (read-only), 2 divider control, 3 control entry. Writing the start value clears the prescaler and restarts the countdown, so the timer is re-armed on every such write.

Top module: `ltmr`

## Requirements
- R1: After reset, the start value, live count and divider control all read 0. The control entry reads 0x0001_0000, which is mask set, one-shot mode and vector 0.
- R2: The divider control keeps only written bits 0, 1 and 3, so it reads back as `wdata & 0xB`.
- R3: The divider code is {bit3, bit1, bit0}, the shift is (code + 1) mod 8, and the divisor D is 2^shift: code 7 gives D = 1 and code 0 gives D = 2. The live count drops by one every D cycles. The first drop comes D cycles after the start-value write.
- R4: In one-shot mode (entry bit 17 = 0) with start value N > 0, the count runs down to 0 and stays there. Exactly one request is raised, (N+1)·D cycles after the write.
- R5: In periodic mode (entry bit 17 = 1) with N > 0, the count goes from 0 back to N, and a request is raised every (N+1)·D cycles.
- R6: A start value of 0 raises no request in either mode.
- R7: While entry bit 16 (mask) is set at the moment of expiry, no request is raised, but the count still runs.
- R8: `irq_valid` is high for exactly one cycle per expiry. `irq_vector` then equals entry bits 7:0.
- R9: The control entry stores only bits 17, 16 and 7:0. All other bits read 0.
- R10: Writes to the live-count address (1) are ignored.
- R11: Writing the start value while a countdown is running restarts it from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, committed at the rising edge |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The write edge is taken as cycle 0.
- The live count changes at edge k·D and is visible on the next falling edge.
- The request is registered on the expiry edge at (N+1)·D, so it is first seen on the falling edge that follows it.

The bench samples only at falling edges and counts them from the one right after the write edge. A measured delay or gap therefore equals (N+1)·D exactly. Read data is sampled just after the address settles within the same low phase.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  localparam int MAX_SHIFT = 7;
  localparam int SHIFT_W   = 3;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_LIVE  = 2'd1,
    SEL_DIV   = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       periodic;
    logic       masked;
    logic [7:0] vector;
  } ctrl_t;

  // divider code: bit3 becomes code bit 2, bits 1:0 stay in place
  function automatic logic [SHIFT_W-1:0] div_code(input logic [3:0] raw);
    return {raw[3], raw[1:0]};
  endfunction

  // shift amount wraps modulo 8, so code 7 means divide by one
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [SHIFT_W-1:0] code);
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/ltmr_regs.sv
module ltmr_regs
  import ltmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  start_cnt,
  output logic [3:0]        div_raw,
  output ctrl_t             ctrl,
  output logic              load
);
  localparam int PAD_W = DATA_W - 18;

  reg_sel_e sel;
  assign sel  = reg_sel_e'(addr);
  assign load = wr && (sel == SEL_START);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_cnt <= '0;
      div_raw   <= '0;
      ctrl      <= '{periodic: 1'b0, masked: 1'b1, vector: 8'd0};
    end else if (wr) begin
      unique case (sel)
        SEL_START: start_cnt <= wdata[CNT_W-1:0];
        SEL_DIV:   div_raw   <= wdata[3:0] & 4'hB;
        SEL_CTRL:  ctrl      <= '{periodic: wdata[17], masked: wdata[16],
                                  vector: wdata[7:0]};
        default:   ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_START: rdata = DATA_W'(start_cnt);
      SEL_LIVE:  rdata = DATA_W'(live_cnt);
      SEL_DIV:   rdata = DATA_W'(div_raw);
      default:   rdata = {{PAD_W{1'b0}}, ctrl.periodic, ctrl.masked, 8'd0, ctrl.vector};
    endcase
  end
endmodule

// File: rtl/ltmr_prescaler.sv
module ltmr_prescaler
  import ltmr_pkg::*;
#(
  parameter int PRE_W = MAX_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] low_mask;

  assign low_mask = ~({PRE_W{1'b1}} << shift);
  assign tick     = &(pre_cnt | ~low_mask);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) pre_cnt <= '0;
    else                 pre_cnt <= pre_cnt + 1'b1;
  end

  // R3: a restart zeroes the prescaler
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_cnt == '0));
endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] live_cnt,
  output logic             expire
);
  logic armed;
  logic at_zero;

  assign at_zero = (live_cnt == '0);
  assign expire  = tick && !load && at_zero &&
                   (periodic ? (start_cnt != '0) : armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_cnt <= '0;
      armed    <= 1'b0;
    end else if (load) begin
      live_cnt <= load_val;
      armed    <= (load_val != '0);
    end else if (tick) begin
      if (!at_zero)              live_cnt <= live_cnt - 1'b1;
      else if (expire && periodic) live_cnt <= start_cnt;
      else if (expire)           armed    <= 1'b0;
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !at_zero) |=> (live_cnt == $past(live_cnt) - 1'b1));

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && at_zero && !load) |=> (live_cnt == '0));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && at_zero && periodic) |=> (live_cnt == $past(start_cnt)));
endmodule

// File: rtl/ltmr.sv
module ltmr
  import ltmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_valid,
  output logic [7:0]        irq_vector
);
  logic [CNT_W-1:0]   start_cnt;
  logic [CNT_W-1:0]   live_cnt;
  logic [3:0]         div_raw;
  logic [SHIFT_W-1:0] shift;
  ctrl_t              ctrl;
  logic               load;
  logic               tick;
  logic               expire;

  assign shift = code_to_shift(div_code(div_raw));

  ltmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .live_cnt(live_cnt), .rdata(reg_rdata), .start_cnt(start_cnt),
    .div_raw(div_raw), .ctrl(ctrl), .load(load)
  );

  ltmr_prescaler #(.PRE_W(MAX_SHIFT)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(load), .shift(shift), .tick(tick)
  );

  ltmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(reg_wdata[CNT_W-1:0]),
    .start_cnt(start_cnt), .periodic(ctrl.periodic), .tick(tick),
    .live_cnt(live_cnt), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= expire && !ctrl.masked;
      irq_vector <= ctrl.vector;
    end
  end

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);

  p_masked_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(ctrl.masked));
endmodule

// File: tb/ltmr_tb.sv
`timescale 1ns/1ps
module ltmr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ltmr u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  localparam int NV = 8;
  localparam int T_DIV [NV] = '{32'hB, 32'h0, 32'h1, 32'h8, 32'h3, 32'hA, 32'h2, 32'h9};
  localparam int T_PER [NV] = '{0, 1, 0, 1, 0, 0, 1, 0};
  localparam int T_VEC [NV] = '{8'h21, 8'h32, 8'h40, 8'h55, 8'h66, 8'h77, 8'h88, 8'hFE};
  localparam int T_N   [NV] = '{3, 2, 5, 1, 2, 1, 3, 1};

  function automatic int divisor(input int raw);
    int code;
    code = ((raw >> 1) & 4) | (raw & 3);
    return (code == 7) ? 1 : (2 << code);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_pulse(input int max, output int c);
    bit found = 0;
    c = 0;
    while (c < max && !found) begin
      @(negedge clk);
      c++;
      if (irq_valid) found = 1;
    end
    if (!found) c = -1;
  endtask

  task automatic count_pulses(input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (irq_valid) n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, c, n, d, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(2'd0, v); chk("R1 start", v, 0);
    rd(2'd1, v); chk("R1 live", v, 0);
    rd(2'd2, v); chk("R1 div", v, 0);
    rd(2'd3, v); chk("R1 ctrl", v, 32'h0001_0000);
    chk("R1 irq", irq_valid, 0);

    // R2 and R9 field retention
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R2 div readback", v, 32'hB);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R9 ctrl readback", v, 32'h0003_00FF);
    wr(2'd3, 32'h0001_0000);

    // table walk: R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      d = divisor(T_DIV[i]);
      e = (T_N[i] + 1) * d;
      wr(2'd2, T_DIV[i]);
      wr(2'd3, (T_PER[i] << 17) | T_VEC[i]);
      wr(2'd0, T_N[i]);
      wait_pulse(e + 10, c);
      if (T_PER[i] != 0) chk("R5 first expiry", c, e);
      else               chk("R4 expiry delay", c, e);
      chk("R8 vector", irq_vector, T_VEC[i]);
      @(negedge clk);
      chk("R8 one cycle", irq_valid, 0);
      if (T_PER[i] != 0) begin
        wait_pulse(e + 10, c);
        chk("R5 period gap", c + 1, e);
      end else begin
        count_pulses(e + 4, n);
        chk("R4 single pulse", n, 0);
        rd(2'd1, v); chk("R4 hold zero", v, 0);
      end
      wr(2'd3, 32'h0001_0000);
      wr(2'd0, 0);
    end

    // R3 step timing, divisor 4
    wr(2'd3, 32'h0001_0000);
    wr(2'd2, 32'h1);
    wr(2'd0, 20);
    rd(2'd1, v); chk("R3 no early step", v, 20);
    repeat (3) @(negedge clk);
    rd(2'd1, v); chk("R3 before first step", v, 20);
    @(negedge clk);
    rd(2'd1, v); chk("R3 first step", v, 19);
    repeat (4) @(negedge clk);
    rd(2'd1, v); chk("R3 second step", v, 18);

    // R10 write to live count ignored (divisor 128)
    wr(2'd2, 32'hA);
    wr(2'd0, 9);
    wr(2'd1, 32'h1234);
    rd(2'd1, v); chk("R10 live unchanged", v, 9);

    // R6 zero start in both modes
    wr(2'd2, 32'hB);
    wr(2'd3, 32'h0002_0011);
    wr(2'd0, 0);
    count_pulses(40, n); chk("R6 periodic zero", n, 0);
    wr(2'd3, 32'h0000_0011);
    wr(2'd0, 0);
    count_pulses(40, n); chk("R6 oneshot zero", n, 0);

    // R7 masked: no request, count still runs
    wr(2'd3, 32'h0001_0012);
    wr(2'd0, 2);
    count_pulses(12, n); chk("R7 masked pulses", n, 0);
    rd(2'd1, v); chk("R7 count ran", v, 0);

    // R11 restart mid-count
    wr(2'd3, 32'h0000_0013);
    wr(2'd0, 10);
    repeat (4) @(negedge clk);
    wr(2'd0, 3);
    wait_pulse(20, c); chk("R11 restart delay", c, 4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule